// File: doc/BRIEF.md
# Ping-Pong DMA Channel

This block is one DMA channel that moves a single data item per peripheral request, either from a peripheral data port into RAM or from RAM out to the peripheral. Software sets it up through a small write port. The registers are a control word, primary and secondary RAM start addresses, a peripheral address and a transfer count. The control word selects the item size, the direction, the point at which the interrupt fires, a null-write mode, one of three RAM addressing schemes and one of four operating modes.

Each accepted request runs one read on the source port and then one write on the destination port. The request port, the RAM port and the peripheral port all use valid/ready handshakes. A valid output stays high, with its address, write flag and data held, until the matching ready is seen at a clock edge. The block tolerates ready being low for any number of cycles on either port. It accepts a new request only when it is idle and enabled. The channel counts transfers against the programmed count. It emits a one-cycle interrupt pulse. In ping-pong modes it alternates between the two RAM buffers. In one-shot modes it clears its own enable.

Top module: `dma_pp_chan`

## Requirements
- R1: After reset the enable is clear, the active buffer is primary, and req_ready, ram_valid, per_valid and blk_irq are all low.
- R2: A write with cfg_sel 0 loads the control word, 1 the primary start, 2 the secondary start, 3 the peripheral address, and 4 the count. Bit 0 of the control word is the enable. While the enable is clear, req_ready stays low and no RAM or peripheral write occurs.
- R3: Control bit 2 picks the direction. With bit 2 clear, a transfer reads the peripheral at the peripheral address and then writes RAM. With bit 2 set, it reads RAM and then writes the peripheral at the peripheral address.
- R4: Control bit 1 picks the size. When set, items are bytes, the RAM address steps by 1, RAM address bit 0 selects the byte lane (ram_be 01 for even, 10 for odd), a RAM write carries the byte on both lanes, and the peripheral side carries the byte in bits 7:0 with bits 15:8 zero. When clear, items are 16-bit words, the step is 2 and ram_be is 11.
- R5: Control bits 6:5 pick the RAM address. Code 00 gives the active start plus the transfer index times the step. Code 01 gives the active start on every transfer. Code 10 gives the active start plus the req_ofs value captured with the request. Code 11 behaves as 01.
- R6: The count register holds N-1 for a block of N transfers. The transfer whose index equals the count ends the block, and the next transfer starts again at index 0.
- R7: blk_irq is a one-cycle pulse in the cycle after a transfer completes. With control bit 3 clear, it fires after the block-ending transfer. With bit 3 set, it fires instead after the transfer whose index equals the count shifted right by one.
- R8: With control bit 4 set and bit 2 clear, every RAM write is accompanied by a peripheral write of zero to the peripheral address. With bit 2 set, bit 4 has no effect.
- R9: Control bits 8:7 pick the operating mode. Bit 7 set means one-shot and bit 8 set means ping-pong. In continuous mode the enable stays set across block ends. In one-shot mode without ping-pong the enable clears at block end.
- R10: In ping-pong mode the first block uses the primary start, and the active buffer flips at every block end. In one-shot ping-pong mode the enable clears at the end of the secondary block.
- R11: A control-word write restarts the channel on the primary buffer at index 0. When it lands in the same cycle as a self-clear of the enable, the written enable wins, and the interrupt for the completed transfer still fires.
- R12: A valid on the RAM or peripheral port holds, with its address, write flag and data stable, until ready is seen. Each transfer makes exactly one source read and its destination writes, regardless of back-pressure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select |
| cfg_wdata | input | 32 | Register write data |
| req_valid | input | 1 | Peripheral transfer request |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_ofs | input | OFS_W | RAM offset for peripheral-indirect addressing |
| ram_valid | output | 1 | RAM access valid |
| ram_ready | input | 1 | RAM access accepted |
| ram_we | output | 1 | RAM write (1) or read (0) |
| ram_addr | output | ADDR_W | RAM byte address |
| ram_be | output | 2 | RAM byte lane enables |
| ram_wdata | output | 16 | RAM write data |
| ram_rdata | input | 16 | RAM read data, valid with ram_ready |
| per_valid | output | 1 | Peripheral access valid |
| per_ready | input | 1 | Peripheral access accepted |
| per_we | output | 1 | Peripheral write (1) or read (0) |
| per_addr | output | PADDR_W | Peripheral address |
| per_wdata | output | 16 | Peripheral write data |
| per_rdata | input | 16 | Peripheral read data, valid with per_ready |
| blk_irq | output | 1 | Block or half-block interrupt pulse |
| chan_en | output | 1 | Current enable bit |
| buf_sel | output | 1 | Active buffer, 0 primary, 1 secondary |

## Verification
The sharpest coincidence is a software control-word write that is sampled on the same clock edge as the final write of a one-shot block, which is the edge where the channel would clear its own enable. The bench forces both readies high so the transfer timing is exact, places the control write on that edge, and then checks three things: the enable is still set, the interrupt still pulsed once, and the next transfer lands at the primary start. A second overlap, a RAM write and a null peripheral write in the same cycle, is provoked under random back-pressure. Both write counts and the zero data are checked there.

// File: rtl/dmapp_pkg.sv
package dmapp_pkg;

  localparam int DATA_W = 16;
  localparam int BE_W   = DATA_W / 8;

  localparam logic [2:0] SEL_CTRL = 3'd0;
  localparam logic [2:0] SEL_PRIM = 3'd1;
  localparam logic [2:0] SEL_SEC  = 3'd2;
  localparam logic [2:0] SEL_PER  = 3'd3;
  localparam logic [2:0] SEL_CNT  = 3'd4;

  typedef enum logic [1:0] {
    AM_POSTINC = 2'b00,
    AM_FIXED   = 2'b01,
    AM_PERIND  = 2'b10,
    AM_RSVD    = 2'b11
  } amode_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2
  } xst_t;

  typedef struct packed {
    logic [1:0] opmode;   // [1] ping-pong, [0] one-shot
    amode_t     amode;
    logic       nullw;
    logic       half;
    logic       to_per;
    logic       byte_sz;
    logic       en;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/dmapp_regs.sv
module dmapp_regs
  import dmapp_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int CNT_W   = 14,
  parameter int PADDR_W = 16,
  parameter int CFG_W   = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [2:0]         cfg_sel,
  input  logic [CFG_W-1:0]   cfg_wdata,
  input  logic               auto_clr,
  output ctrl_t              ctrl,
  output logic               ctrl_wr,
  output logic [ADDR_W-1:0]  prim,
  output logic [ADDR_W-1:0]  sec,
  output logic [PADDR_W-1:0] per_cfg,
  output logic [CNT_W-1:0]   cnt_cfg
);

  assign ctrl_wr = cfg_we && (cfg_sel == SEL_CTRL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
    end else if (ctrl_wr) begin
      ctrl <= ctrl_t'(cfg_wdata[CTRL_W-1:0]);
    end else if (auto_clr) begin
      ctrl.en <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prim    <= '0;
      sec     <= '0;
      per_cfg <= '0;
      cnt_cfg <= '0;
    end else if (cfg_we) begin
      case (cfg_sel)
        SEL_PRIM: prim    <= cfg_wdata[ADDR_W-1:0];
        SEL_SEC:  sec     <= cfg_wdata[ADDR_W-1:0];
        SEL_PER:  per_cfg <= cfg_wdata[PADDR_W-1:0];
        SEL_CNT:  cnt_cfg <= cfg_wdata[CNT_W-1:0];
        default:  ;
      endcase
    end
  end

endmodule

// File: rtl/dmapp_addr_gen.sv
module dmapp_addr_gen
  import dmapp_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFS_W  = 16
) (
  input  logic [ADDR_W-1:0] prim,
  input  logic [ADDR_W-1:0] sec,
  input  logic              buf_sel,
  input  amode_t            amode,
  input  logic [ADDR_W-1:0] lin_ofs,
  input  logic [OFS_W-1:0]  ofs_q,
  output logic [ADDR_W-1:0] ram_addr
);

  logic [ADDR_W-1:0] base;
  logic [ADDR_W-1:0] ofs_ext;
  logic [ADDR_W-1:0] delta;

  assign base = buf_sel ? sec : prim;

  generate
    if (OFS_W >= ADDR_W) begin : g_ofs_trunc
      assign ofs_ext = ofs_q[ADDR_W-1:0];
    end else begin : g_ofs_ext
      assign ofs_ext = {{(ADDR_W-OFS_W){1'b0}}, ofs_q};
    end
  endgenerate

  always_comb begin
    case (amode)
      AM_POSTINC: delta = lin_ofs;
      AM_PERIND:  delta = ofs_ext;
      default:    delta = '0;
    endcase
  end

  assign ram_addr = base + delta;

endmodule

// File: rtl/dmapp_engine.sv
module dmapp_engine
  import dmapp_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int CNT_W   = 14,
  parameter int OFS_W   = 16,
  parameter int PADDR_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               byte_sz,
  input  logic               to_per,
  input  logic               half,
  input  logic               nullw,
  input  logic [1:0]         opmode,
  input  logic               ctrl_wr,
  input  logic [CNT_W-1:0]   cnt_cfg,
  input  logic [PADDR_W-1:0] per_cfg,
  input  logic               addr_lsb,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [OFS_W-1:0]   req_ofs,
  output logic [OFS_W-1:0]   ofs_q,
  output logic [ADDR_W-1:0]  lin_ofs,
  output logic               buf_sel,
  output logic               ram_valid,
  input  logic               ram_ready,
  output logic               ram_we,
  output logic [BE_W-1:0]    ram_be,
  output logic [DATA_W-1:0]  ram_wdata,
  input  logic [DATA_W-1:0]  ram_rdata,
  output logic               per_valid,
  input  logic               per_ready,
  output logic               per_we,
  output logic [PADDR_W-1:0] per_addr,
  output logic [DATA_W-1:0]  per_wdata,
  input  logic [DATA_W-1:0]  per_rdata,
  output logic               blk_irq,
  output logic               auto_clr
);

  localparam int HALF_W = DATA_W / 2;

  xst_t              state;
  logic [DATA_W-1:0] data_q;
  logic              ram_done, per_done;
  logic [CNT_W-1:0]  xfer_cnt;
  logic              irq_q;

  logic              null_on, need_ram_wr, need_per_wr;
  logic              ram_ok, per_ok, xfer_done, blk_end, half_pt;
  logic              pingpong, oneshot;
  logic [ADDR_W-1:0] step;
  logic [DATA_W-1:0] rd_ram_item, rd_per_item;

  assign pingpong    = opmode[1];
  assign oneshot     = opmode[0];
  assign null_on     = nullw && !to_per;
  assign need_ram_wr = !to_per;
  assign need_per_wr = to_per || null_on;
  assign step        = byte_sz ? ADDR_W'(1) : ADDR_W'(2);

  // source side byte-lane steering
  always_comb begin
    if (byte_sz) begin
      rd_ram_item = {{HALF_W{1'b0}}, addr_lsb ? ram_rdata[DATA_W-1:HALF_W] : ram_rdata[HALF_W-1:0]};
      rd_per_item = {{HALF_W{1'b0}}, per_rdata[HALF_W-1:0]};
    end else begin
      rd_ram_item = ram_rdata;
      rd_per_item = per_rdata;
    end
  end

  // bus request generation
  assign req_ready = (state == ST_IDLE) && en;
  assign ram_valid = ((state == ST_RD) && to_per) ||
                     ((state == ST_WR) && need_ram_wr && !ram_done);
  assign per_valid = ((state == ST_RD) && !to_per) ||
                     ((state == ST_WR) && need_per_wr && !per_done);
  assign ram_we    = (state == ST_WR);
  assign per_we    = (state == ST_WR);
  assign per_addr  = per_cfg;
  assign per_wdata = null_on ? '0 : data_q;
  assign ram_wdata = byte_sz ? {data_q[HALF_W-1:0], data_q[HALF_W-1:0]} : data_q;
  assign ram_be    = byte_sz ? (addr_lsb ? 2'b10 : 2'b01) : 2'b11;

  // completion of the destination phase
  assign ram_ok    = !need_ram_wr || ram_done || ram_ready;
  assign per_ok    = !need_per_wr || per_done || per_ready;
  assign xfer_done = (state == ST_WR) && ram_ok && per_ok;
  assign blk_end   = (xfer_cnt == cnt_cfg);
  assign half_pt   = (xfer_cnt == (cnt_cfg >> 1));
  assign auto_clr  = xfer_done && blk_end && oneshot && (!pingpong || buf_sel);
  assign blk_irq   = irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      data_q   <= '0;
      ram_done <= 1'b0;
      per_done <= 1'b0;
      ofs_q    <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (req_valid && req_ready) begin
            ofs_q <= req_ofs;
            state <= ST_RD;
          end
        end
        ST_RD: begin
          ram_done <= 1'b0;
          per_done <= 1'b0;
          if (to_per && ram_ready) begin
            data_q <= rd_ram_item;
            state  <= ST_WR;
          end else if (!to_per && per_ready) begin
            data_q <= rd_per_item;
            state  <= ST_WR;
          end
        end
        ST_WR: begin
          if (xfer_done) begin
            state <= ST_IDLE;
          end else begin
            ram_done <= ram_done || (ram_valid && ram_ready);
            per_done <= per_done || (per_valid && per_ready);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // progress through the block and the buffer pair
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xfer_cnt <= '0;
      lin_ofs  <= '0;
      buf_sel  <= 1'b0;
    end else if (ctrl_wr) begin
      xfer_cnt <= '0;
      lin_ofs  <= '0;
      buf_sel  <= 1'b0;
    end else if (xfer_done) begin
      if (blk_end) begin
        xfer_cnt <= '0;
        lin_ofs  <= '0;
        if (pingpong) buf_sel <= !buf_sel;
      end else begin
        xfer_cnt <= xfer_cnt + CNT_W'(1);
        lin_ofs  <= lin_ofs + step;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= xfer_done && (half ? half_pt : blk_end);
  end

endmodule

// File: rtl/dma_pp_chan.sv
module dma_pp_chan
  import dmapp_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int CNT_W   = 14,
  parameter int OFS_W   = 16,
  parameter int PADDR_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [2:0]         cfg_sel,
  input  logic [31:0]        cfg_wdata,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [OFS_W-1:0]   req_ofs,
  output logic               ram_valid,
  input  logic               ram_ready,
  output logic               ram_we,
  output logic [ADDR_W-1:0]  ram_addr,
  output logic [1:0]         ram_be,
  output logic [15:0]        ram_wdata,
  input  logic [15:0]        ram_rdata,
  output logic               per_valid,
  input  logic               per_ready,
  output logic               per_we,
  output logic [PADDR_W-1:0] per_addr,
  output logic [15:0]        per_wdata,
  input  logic [15:0]        per_rdata,
  output logic               blk_irq,
  output logic               chan_en,
  output logic               buf_sel
);

  ctrl_t              ctrl_q;
  logic               ctrl_wr;
  logic               auto_clr;
  logic [ADDR_W-1:0]  prim, sec, lin_ofs;
  logic [PADDR_W-1:0] per_cfg;
  logic [CNT_W-1:0]   cnt_cfg;
  logic [OFS_W-1:0]   ofs_q;

  assign chan_en = ctrl_q.en;

  dmapp_regs #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .PADDR_W(PADDR_W), .CFG_W(32)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .auto_clr(auto_clr), .ctrl(ctrl_q),
    .ctrl_wr(ctrl_wr), .prim(prim), .sec(sec), .per_cfg(per_cfg),
    .cnt_cfg(cnt_cfg)
  );

  dmapp_addr_gen #(
    .ADDR_W(ADDR_W), .OFS_W(OFS_W)
  ) u_agen (
    .prim(prim), .sec(sec), .buf_sel(buf_sel), .amode(ctrl_q.amode),
    .lin_ofs(lin_ofs), .ofs_q(ofs_q), .ram_addr(ram_addr)
  );

  dmapp_engine #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .OFS_W(OFS_W), .PADDR_W(PADDR_W)
  ) u_eng (
    .clk(clk), .rst_n(rst_n), .en(ctrl_q.en), .byte_sz(ctrl_q.byte_sz),
    .to_per(ctrl_q.to_per), .half(ctrl_q.half), .nullw(ctrl_q.nullw),
    .opmode(ctrl_q.opmode), .ctrl_wr(ctrl_wr), .cnt_cfg(cnt_cfg),
    .per_cfg(per_cfg), .addr_lsb(ram_addr[0]), .req_valid(req_valid),
    .req_ready(req_ready), .req_ofs(req_ofs), .ofs_q(ofs_q),
    .lin_ofs(lin_ofs), .buf_sel(buf_sel), .ram_valid(ram_valid),
    .ram_ready(ram_ready), .ram_we(ram_we), .ram_be(ram_be),
    .ram_wdata(ram_wdata), .ram_rdata(ram_rdata), .per_valid(per_valid),
    .per_ready(per_ready), .per_we(per_we), .per_addr(per_addr),
    .per_wdata(per_wdata), .per_rdata(per_rdata), .blk_irq(blk_irq),
    .auto_clr(auto_clr)
  );

endmodule

// File: rtl/dmapp_chk.sv
module dmapp_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              chan_en,
  input logic              blk_irq,
  input logic              ram_valid,
  input logic              ram_ready,
  input logic              ram_we,
  input logic [ADDR_W-1:0] ram_addr,
  input logic [1:0]        ram_be,
  input logic [15:0]       ram_wdata,
  input logic              per_valid,
  input logic              per_ready,
  input logic              per_we,
  input logic [15:0]       per_wdata,
  input logic              byte_mode
);

  p_ready_needs_en_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> chan_en);

  p_irq_one_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    blk_irq |=> !blk_irq);

  p_ram_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_valid && !ram_ready) |=>
      (ram_valid && $stable(ram_addr) && $stable(ram_we) && $stable(ram_wdata)));

  p_per_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (per_valid && !per_ready) |=>
      (per_valid && $stable(per_we) && $stable(per_wdata)));

  p_null_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_valid && ram_we && per_valid && per_we) |-> (per_wdata == 16'h0000));

  p_byte_lane_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_valid && ram_we && byte_mode) |-> ($countones(ram_be) == 1));

  p_one_source_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(ram_valid && !ram_we && per_valid && !per_we));

endmodule

bind dma_pp_chan dmapp_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .chan_en(chan_en),
  .blk_irq(blk_irq), .ram_valid(ram_valid), .ram_ready(ram_ready),
  .ram_we(ram_we), .ram_addr(ram_addr), .ram_be(ram_be),
  .ram_wdata(ram_wdata), .per_valid(per_valid), .per_ready(per_ready),
  .per_we(per_we), .per_wdata(per_wdata), .byte_mode(ctrl_q.byte_sz)
);

// File: tb/dma_pp_chan_tb.sv
module dma_pp_chan_tb;

  localparam int ADDR_W = 32, CNT_W = 14, OFS_W = 16, PADDR_W = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic req_valid = 1'b0, req_ready;
  logic [OFS_W-1:0] req_ofs = '0;
  logic ram_valid, ram_ready = 1'b0, ram_we;
  logic [ADDR_W-1:0] ram_addr;
  logic [1:0] ram_be;
  logic [15:0] ram_wdata, ram_rdata;
  logic per_valid, per_ready = 1'b0, per_we;
  logic [PADDR_W-1:0] per_addr;
  logic [15:0] per_wdata, per_rdata;
  logic blk_irq, chan_en, buf_sel;

  always #2 clk = ~clk;

  dma_pp_chan #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .OFS_W(OFS_W), .PADDR_W(PADDR_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_ofs(req_ofs),
    .ram_valid(ram_valid), .ram_ready(ram_ready), .ram_we(ram_we), .ram_addr(ram_addr),
    .ram_be(ram_be), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
    .per_valid(per_valid), .per_ready(per_ready), .per_we(per_we), .per_addr(per_addr),
    .per_wdata(per_wdata), .per_rdata(per_rdata), .blk_irq(blk_irq),
    .chan_en(chan_en), .buf_sel(buf_sel));

  int n_chk = 0, n_fail = 0;
  logic [15:0] mem [256];
  int per_rd_n = 0;
  int n_ram_wr = 0, n_per_wr = 0, n_irq = 0;
  logic [ADDR_W-1:0] last_ram_addr;
  logic [15:0] last_ram_wdata, last_per_wdata;
  logic [1:0] last_ram_be;
  logic [PADDR_W-1:0] last_per_addr;
  logic p_rd = 1'b0, p_wr = 1'b0, force_rdy = 1'b0;
  logic [ADDR_W-1:0] p_addr;
  logic [15:0] p_data;
  logic [1:0] p_be;

  // bench configuration and model state
  logic [8:0] c_ctrl;
  logic [31:0] c_prim, c_sec;
  logic [15:0] c_pa;
  int c_cnt, m_i, m_buf, m_en;

  function automatic logic [15:0] pdat(input int n);
    logic [15:0] v;
    v = 16'(n) * 16'h0107;
    return 16'h3C5A ^ v;
  endfunction

  assign ram_rdata = mem[ram_addr[8:1]];
  assign per_rdata = pdat(per_rd_n);

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // slave models and port monitor
  initial begin
    void'($urandom(32'd20240611));
    for (int j = 0; j < 256; j++) mem[j] = 16'(j) * 16'h0305 ^ 16'h1234;
    forever begin
      @(negedge clk);
      if (p_rd) begin per_rd_n++; p_rd = 1'b0; end
      if (p_wr) begin
        if (p_be[0]) mem[p_addr[8:1]][7:0]  = p_data[7:0];
        if (p_be[1]) mem[p_addr[8:1]][15:8] = p_data[15:8];
        p_wr = 1'b0;
      end
      ram_ready = force_rdy || ($urandom % 3 != 0);
      per_ready = force_rdy || ($urandom % 3 != 0);
      #1;
      if (rst_n) begin
        if (ram_valid && ram_ready && ram_we) begin
          n_ram_wr++; last_ram_addr = ram_addr; last_ram_wdata = ram_wdata; last_ram_be = ram_be;
          p_wr = 1'b1; p_addr = ram_addr; p_data = ram_wdata; p_be = ram_be;
        end
        if (per_valid && per_ready && per_we) begin
          n_per_wr++; last_per_addr = per_addr; last_per_wdata = per_wdata;
        end
        if (per_valid && per_ready && !per_we) p_rd = 1'b1;
        if (blk_irq) n_irq++;
      end
    end
  end

  initial begin
    #(4 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  task automatic cfgw(input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (sel == 3'd0) begin c_ctrl = d[8:0]; m_i = 0; m_buf = 0; m_en = int'(d[0]); end
  endtask

  task automatic setup(input logic [8:0] ctrl, input logic [31:0] pr, input logic [31:0] se,
                       input logic [15:0] pa, input int cnt);
    c_prim = pr; c_sec = se; c_pa = pa; c_cnt = cnt;
    cfgw(3'd1, pr); cfgw(3'd2, se); cfgw(3'd3, {16'h0, pa}); cfgw(3'd4, cnt);
    cfgw(3'd0, {23'h0, ctrl});
  endtask

  // bench-side expectation for one transfer, then issue and compare
  task automatic run_one(input logic [15:0] ofs);
    logic bm, tp, hf, nl;
    logic [1:0] am, op;
    logic [31:0] base, ea, stp;
    logic [15:0] pd, w, exp_item;
    int irq0, rw0, pw0, exp_rw, exp_pw, exp_irq;
    bit bend;
    bm = c_ctrl[1]; tp = c_ctrl[2]; hf = c_ctrl[3]; nl = c_ctrl[4];
    am = c_ctrl[6:5]; op = c_ctrl[8:7];
    base = (m_buf != 0) ? c_sec : c_prim;
    stp = bm ? 32'd1 : 32'd2;
    case (am)
      2'b00:   ea = base + 32'(m_i) * stp;
      2'b10:   ea = base + 32'(ofs);
      default: ea = base;
    endcase
    pd = pdat(per_rd_n);
    w = mem[ea[8:1]];
    irq0 = n_irq; rw0 = n_ram_wr; pw0 = n_per_wr;
    exp_rw = tp ? 0 : 1;
    exp_pw = tp ? 1 : (nl ? 1 : 0);

    @(negedge clk); req_valid = 1'b1; req_ofs = ofs; #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(posedge clk); @(negedge clk); req_valid = 1'b0;
    while (n_ram_wr + n_per_wr < rw0 + pw0 + exp_rw + exp_pw) begin @(negedge clk); #2; end
    @(negedge clk); #2; @(negedge clk); #2;

    check(n_ram_wr - rw0 == exp_rw && n_per_wr - pw0 == exp_pw, "R12 write count",
          32'((n_ram_wr - rw0) * 16 + (n_per_wr - pw0)), 32'(exp_rw * 16 + exp_pw));
    if (!tp) begin
      exp_item = bm ? {pd[7:0], pd[7:0]} : pd;
      check(last_ram_addr == ea, "R5/R6 ram address", last_ram_addr, ea);
      check(last_ram_wdata == exp_item, "R3 ram write data", 32'(last_ram_wdata), 32'(exp_item));
      check(last_ram_be == (bm ? (ea[0] ? 2'b10 : 2'b01) : 2'b11), "R4 byte enables",
            32'(last_ram_be), 32'(bm ? (ea[0] ? 2'b10 : 2'b01) : 2'b11));
      if (nl) check(last_per_wdata == 16'h0 && last_per_addr == c_pa, "R8 null write",
                    {last_per_addr, last_per_wdata}, {c_pa, 16'h0});
    end else begin
      exp_item = bm ? {8'h00, (ea[0] ? w[15:8] : w[7:0])} : w;
      check(last_per_wdata == exp_item && last_per_addr == c_pa, "R3/R4 peripheral write",
            {last_per_addr, last_per_wdata}, {c_pa, exp_item});
    end
    bend = (m_i == c_cnt);
    exp_irq = hf ? int'(m_i == (c_cnt >> 1)) : int'(bend);
    check(n_irq - irq0 == exp_irq, "R7 interrupt", 32'(n_irq - irq0), 32'(exp_irq));
    if (bend) begin
      m_i = 0;
      if (op[0] && (!op[1] || m_buf != 0)) m_en = 0;
      if (op[1]) m_buf = 1 - m_buf;
    end else m_i++;
    check(chan_en == m_en[0], "R9 enable", 32'(chan_en), 32'(m_en));
    check(buf_sel == m_buf[0], "R10 buffer", 32'(buf_sel), 32'(m_buf));
  endtask

  initial begin
    int rw0, irq0, nx;
    logic [8:0] rc;
    repeat (4) @(negedge clk);
    #1;
    // R1: reset state (sampled while reset is held)
    check(!chan_en && !req_ready && !blk_irq && !buf_sel && !ram_valid && !per_valid,
          "R1 reset state", {26'h0, chan_en, req_ready, blk_irq, buf_sel, ram_valid, per_valid}, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #1;
    check(!chan_en && !req_ready && !blk_irq && !buf_sel, "R1 after release",
          {28'h0, chan_en, req_ready, blk_irq, buf_sel}, 32'h0);

    // R2: disabled channel ignores requests
    setup(9'h000, 32'h10, 32'h80, 16'h0042, 3);
    rw0 = n_ram_wr + n_per_wr;
    @(negedge clk); req_valid = 1'b1;
    repeat (6) begin
      @(negedge clk); #1;
      check(!req_ready, "R2 ready while disabled", 32'(req_ready), 32'h0);
    end
    req_valid = 1'b0;
    check(n_ram_wr + n_per_wr == rw0, "R2 no writes while disabled", 32'(n_ram_wr + n_per_wr), 32'(rw0));

    // word, peripheral to RAM, post-increment, continuous, N=3
    setup(9'b00_00_0_0_0_0_1, 32'h20, 32'h90, 16'h0011, 2);
    for (int k = 0; k < 5; k++) run_one(16'h0);
    // byte, RAM to peripheral, fixed address at odd start, one-shot
    setup(9'b01_01_0_0_1_1_1, 32'h33, 32'h90, 16'h0022, 1);
    for (int k = 0; k < 2; k++) run_one(16'h0);
    // peripheral-indirect with null writes, word size
    setup(9'b00_10_1_0_0_0_1, 32'h40, 32'h90, 16'h0033, 3);
    run_one(16'h0006); run_one(16'h001A); run_one(16'h0000); run_one(16'h0010);
    // null bit with direction set is ignored
    setup(9'b00_00_1_0_1_0_1, 32'h50, 32'h90, 16'h0044, 1);
    run_one(16'h0); run_one(16'h0);
    // half-block interrupt, byte post-increment, N=5
    setup(9'b00_00_0_1_0_1_1, 32'h61, 32'h90, 16'h0055, 4);
    for (int k = 0; k < 6; k++) run_one(16'h0);
    // one-shot ping-pong, N=2 each buffer
    setup(9'b11_00_0_0_0_0_1, 32'h70, 32'hA0, 16'h0066, 1);
    for (int k = 0; k < 4; k++) run_one(16'h0);

    // R11: control write on the same edge as the one-shot self-clear
    setup(9'b01_00_0_0_0_0_1, 32'h20, 32'h90, 16'h0077, 1);
    run_one(16'h0);
    force_rdy = 1'b1;
    @(negedge clk); @(negedge clk);
    irq0 = n_irq; rw0 = n_ram_wr;
    req_valid = 1'b1;
    @(negedge clk); req_valid = 1'b0;          // accepted at the edge before
    @(negedge clk);                            // read phase completes at next edge
    cfg_we = 1'b1; cfg_sel = 3'd0; cfg_wdata = 32'h0000_0081;  // sampled with final write
    @(negedge clk); cfg_we = 1'b0;
    @(negedge clk); #2;
    force_rdy = 1'b0;
    check(chan_en == 1'b1, "R11 write wins over self-clear", 32'(chan_en), 32'h1);
    check(n_irq - irq0 == 1 && n_ram_wr - rw0 == 1, "R11 transfer completed with interrupt",
          32'((n_irq - irq0) * 16 + (n_ram_wr - rw0)), 32'h11);
    c_ctrl = 9'h081; m_i = 0; m_buf = 0; m_en = 1;
    run_one(16'h0);

    // constrained random configurations
    for (int it = 0; it < 40; it++) begin
      logic [31:0] pr, se;
      int cnt;
      rc = 9'($urandom) | 9'h001;
      cnt = $urandom % 5;
      pr = $urandom % 200; se = $urandom % 200;
      if (!rc[1]) begin pr[0] = 1'b0; se[0] = 1'b0; end
      setup(rc, pr, se, 16'($urandom), cnt);
      if (rc[7]) nx = rc[8] ? 2 * (cnt + 1) : cnt + 1;
      else nx = 2 * (cnt + 1) + 1;
      for (int k = 0; k < nx; k++) begin
        logic [15:0] o;
        o = 16'($urandom % 48);
        if (!rc[1]) o[0] = 1'b0;
        run_one(o);
      end
    end
    finish_up();
  end

endmodule